// File: doc/BRIEF.md
# DRAM Refresh Timer and Sequencer

This block keeps an asynchronous DRAM alive by counting prescaled clock ticks up to a programmed compare value and raising a refresh request each time the count gets there. The request stays pending until the external bus is free. The block then runs one CAS-before-RAS refresh cycle on active-low strobes. Both the RAS-low width and the following precharge gap come from their own 3-bit length fields.

Software programs the compare value, the count, the mode and enable bits and the strobe lengths first. It writes a nonzero tick select last. The counter then resumes from whatever value it holds. Refresh requests are generated only when distributed refresh is chosen: the self-refresh mode bit is 0 and the enable bit is 1.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: A compare match counts only while `self_mode_i` is 0 and `refresh_en_i` is 1. In any other setting `pending_o` never rises, and no strobe falls unless a request is already pending.
- R2: A free-running 12-bit divider starts at 0 after reset and steps by one each clock, wrapping modulo 4096. For `tick_sel_i` = 1..7 the divisor D is 4, 16, 64, 256, 1024, 2048 or 4096. The count rises by one on each cycle where the divider value modulo D equals D-1. With `tick_sel_i` = 0 the count holds.
- R3: A cycle with `cnt_wr_i` high loads `cnt_wdata_i` into the count on the next edge. A write wins over a match and over a tick. Choosing a nonzero tick select keeps the held value and counts up from it.
- R4: Suppose the count equals `cmp_val_i` while refresh is active and no write is made. On the next edge the count becomes 0 and `pending_o` becomes 1.
- R5: `pending_o` stays high until a refresh cycle starts. A cycle starts in a cycle where `pending_o`, `bus_avail_i` and not-`busy_o` all hold. `pending_o` is 0 one edge later, unless a match fell in that same cycle.
- R6: CAS goes low on the edge after the start cycle. RAS goes low exactly one cycle after CAS.
- R7: With `ras_len_i` = n, RAS stays low for n+1 cycles. CAS rises on the same edge as RAS.
- R8: With `pre_len_i` = m, both strobes stay high for m+1 cycles after RAS rises, with `busy_o` still high. `busy_o` then falls.
- R9: Several matches while a request is already pending merge into a single refresh cycle.
- R10: `busy_o` is high from the first CAS-low cycle through the last precharge cycle. No cycle starts while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| self_mode_i | input | 1 | Refresh mode bit; 1 selects self-refresh and blocks requests |
| refresh_en_i | input | 1 | Refresh enable bit |
| tick_sel_i | input | 3 | Prescaler select; 0 stops the count |
| cmp_val_i | input | CNT_W | Compare constant |
| cnt_wr_i | input | 1 | Write strobe for the count register |
| cnt_wdata_i | input | CNT_W | Value written to the count register |
| ras_len_i | input | 3 | RAS-low length minus one |
| pre_len_i | input | 3 | Precharge length minus one |
| bus_avail_i | input | 1 | External bus free for a refresh cycle |
| pending_o | output | 1 | Refresh request pending |
| ras_no | output | 1 | RAS strobe, active low |
| cas_no | output | 1 | CAS strobe, active low |
| busy_o | output | 1 | Refresh cycle in progress |
| cnt_o | output | CNT_W | Current count value |

## Verification
The count and the pending flag change one edge after the cycle in which their cause appears. That cause is a tick, a match, a write or a start. Each strobe phase therefore begins one edge after the phase before it ends. A behavioural model in the bench advances its state on each rising edge from the same inputs. All outputs are compared with that model at the falling edge, after the design's registers have settled and before any input changes. Inputs change one nanosecond after the falling edge. Directed checks add the measured strobe widths, the CAS lead and the count of refresh cycles that run while the bus is briefly free.

// File: rtl/drf_pkg.sv
package drf_pkg;
  localparam int FIELD_W = 3;
  localparam int PRE_W   = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_CAS, ST_RAS, ST_PRE} cyc_state_e;

  // log2 of the prescaler divisor per select value
  function automatic int sel_shift(input logic [2:0] sel);
    case (sel)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      3'd5: return 10;
      3'd6: return 11;
      3'd7: return 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/drf_prescaler.sv
module drf_prescaler
  import drf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;

  always_comb begin
    mask   = {PRE_W{1'b1}} >> (PRE_W - sel_shift(sel_i));
    tick_o = (sel_i != 3'd0) && ((div_q & mask) == mask);
  end
endmodule

// File: rtl/drf_counter.sv
module drf_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;

  assign match_o = active_i && (cnt_q == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (match_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !match_o && !tick_i) |=> $stable(cnt_q));
  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !wr_i) |=> (cnt_q == '0));
  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/drf_cycle_fsm.sv
module drf_cycle_fsm
  import drf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FIELD_W-1:0] ras_len_i,
  input  logic [FIELD_W-1:0] pre_len_i,
  output logic               ras_no,
  output logic               cas_no,
  output logic               busy_o
);
  cyc_state_e         state_q;
  logic [FIELD_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_CAS;
        ST_CAS: begin
          state_q <= ST_RAS;
          rem_q   <= ras_len_i;
        end
        ST_RAS:
          if (rem_q == '0) begin
            state_q <= ST_PRE;
            rem_q   <= pre_len_i;
          end else rem_q <= rem_q - 1'b1;
        ST_PRE:
          if (rem_q == '0) state_q <= ST_IDLE;
          else             rem_q   <= rem_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end

  assign busy_o = (state_q != ST_IDLE);
  assign cas_no = !((state_q == ST_CAS) || (state_q == ST_RAS));
  assign ras_no = (state_q != ST_RAS);

  // R6
  cas_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (!cas_no && $past(!cas_no)));
  // R7
  cas_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_no) |-> $rose(ras_no));
  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ST_IDLE));
  // R8
  pre_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> (busy_o && cas_no));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import drf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               self_mode_i,
  input  logic               refresh_en_i,
  input  logic [2:0]         tick_sel_i,
  input  logic [CNT_W-1:0]   cmp_val_i,
  input  logic               cnt_wr_i,
  input  logic [CNT_W-1:0]   cnt_wdata_i,
  input  logic [FIELD_W-1:0] ras_len_i,
  input  logic [FIELD_W-1:0] pre_len_i,
  input  logic               bus_avail_i,
  output logic               pending_o,
  output logic               ras_no,
  output logic               cas_no,
  output logic               busy_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic tick, match, active, start, pend_q, busy;

  assign active = !self_mode_i && refresh_en_i;

  drf_prescaler u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (tick_sel_i),
    .tick_o(tick)
  );

  drf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .active_i(active),
    .cmp_i   (cmp_val_i),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (cnt_o),
    .match_o (match)
  );

  assign start = pend_q && bus_avail_i && !busy;

  // a new match outranks the clear at start
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    pend_q <= 1'b0;
    else if (match) pend_q <= 1'b1;
    else if (start) pend_q <= 1'b0;

  drf_cycle_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .ras_len_i(ras_len_i),
    .pre_len_i(pre_len_i),
    .ras_no   (ras_no),
    .cas_no   (cas_no),
    .busy_o   (busy)
  );

  assign busy_o    = busy;
  assign pending_o = pend_q;

  // R5
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !start) |=> pend_q);
  // R4
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> pend_q);
  // R1
  inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !pend_q) |=> !pend_q);
  // R6
  cas_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!cas_no && ras_no));
endmodule

// File: tb/dram_refresh_ctrl_test.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_test;
  localparam int CNT_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic self_mode_i = 1'b0, refresh_en_i = 1'b0, cnt_wr_i = 1'b0, bus_avail_i = 1'b0;
  logic [2:0] tick_sel_i = 3'd0, ras_len_i = 3'd0, pre_len_i = 3'd0;
  logic [CNT_W-1:0] cmp_val_i = '0, cnt_wdata_i = '0;
  logic pending_o, ras_no, cas_no, busy_o;
  logic [CNT_W-1:0] cnt_o;

  int checks = 0, failures = 0;

  always #5 clk_i = ~clk_i;

  dram_refresh_ctrl #(.CNT_W(CNT_W)) uut (.*);

  // behavioural reference model
  int m_div, m_cnt, m_rem, m_ph;
  bit m_pend;

  function automatic int divisor(input int s);
    case (s)
      1: return 4;     2: return 16;   3: return 64;  4: return 256;
      5: return 1024;  6: return 2048; 7: return 4096;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_cnt = 0; m_pend = 0; m_ph = 0; m_rem = 0;
    end else begin
      int d;
      bit tk, act, mt, st;
      d   = divisor(int'(tick_sel_i));
      tk  = (tick_sel_i != 0) && ((m_div % d) == d - 1);
      act = !self_mode_i && refresh_en_i;
      mt  = act && (m_cnt == int'(cmp_val_i));
      st  = m_pend && bus_avail_i && (m_ph == 0);
      if (cnt_wr_i)  m_cnt = int'(cnt_wdata_i);
      else if (mt)   m_cnt = 0;
      else if (tk)   m_cnt = (m_cnt + 1) % (1 << CNT_W);
      if (mt)        m_pend = 1;
      else if (st)   m_pend = 0;
      if (m_ph == 0) begin
        if (st) m_ph = 1;
      end else if (m_ph == 1) begin
        m_ph = 2; m_rem = int'(ras_len_i);
      end else if (m_ph == 2) begin
        if (m_rem == 0) begin m_ph = 3; m_rem = int'(pre_len_i); end
        else m_rem--;
      end else begin
        if (m_rem == 0) m_ph = 0; else m_rem--;
      end
      m_div = (m_div + 1) % 4096;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare and strobe width monitors
  int ras_run = 0, last_ras = 0, pre_run = 0, last_pre = 0, lead_run = 0, last_lead = 0;
  int cas_falls = 0, pend_highs = 0;
  logic cas_prev = 1'b1;

  always @(negedge clk_i) if (rst_ni) begin
    chk(pending_o == m_pend, "R4/R5 pending", pending_o, m_pend);
    chk(cas_no == !(m_ph == 1 || m_ph == 2), "R6/R7 cas", cas_no, !(m_ph == 1 || m_ph == 2));
    chk(ras_no == !(m_ph == 2), "R6/R7 ras", ras_no, !(m_ph == 2));
    chk(busy_o == (m_ph != 0), "R8/R10 busy", busy_o, m_ph != 0);
    chk(int'(cnt_o) == m_cnt, "R2/R3 count", cnt_o, m_cnt);
    if (!ras_no) ras_run++; else if (ras_run > 0) begin last_ras = ras_run; ras_run = 0; end
    if (busy_o && ras_no && cas_no) pre_run++;
    else if (pre_run > 0) begin last_pre = pre_run; pre_run = 0; end
    if (!cas_no && ras_no) lead_run++;
    else if (lead_run > 0) begin last_lead = lead_run; lead_run = 0; end
    if (cas_prev && !cas_no) cas_falls++;
    if (pending_o) pend_highs++;
    cas_prev = cas_no;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic setup(input bit md, input bit en, input int sel, input int cmp,
                       input int rl, input int pl, input bit bus);
    self_mode_i = md; refresh_en_i = en; tick_sel_i = 3'(sel);
    cmp_val_i = CNT_W'(cmp); ras_len_i = 3'(rl); pre_len_i = 3'(pl); bus_avail_i = bus;
  endtask

  task automatic write_cnt(input int v);
    cnt_wr_i = 1'b1; cnt_wdata_i = CNT_W'(v);
    cyc(1);
    cnt_wr_i = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R10 R5 reset state
    chk(!pending_o && ras_no && cas_no && !busy_o && cnt_o == 0, "R10 reset",
        {pending_o, ras_no, cas_no, busy_o}, 4'b0110);

    // R1: self mode and disable block requests
    setup(1, 1, 1, 2, 0, 0, 1);
    pend_highs = 0; cas_falls = 0;
    cyc(300);
    setup(0, 0, 1, 2, 0, 0, 1);
    cyc(300);
    chk(pend_highs == 0 && cas_falls == 0, "R1 no request while inactive", pend_highs, 0);

    // R3: hold at select 0, write, resume
    setup(0, 1, 0, 100, 1, 1, 1);
    write_cnt(7);
    cyc(60);
    chk(cnt_o == 7, "R2 held at select 0", cnt_o, 7);
    tick_sel_i = 3'd1;
    cyc(5);
    chk(cnt_o == 8, "R3 resumes from held count", cnt_o, 8);

    // R6 R7 R8: strobe widths
    setup(0, 1, 1, 3, 5, 7, 1);
    write_cnt(0);
    cyc(200);
    chk(last_ras == 6, "R7 ras width", last_ras, 6);
    chk(last_pre == 8, "R8 precharge width", last_pre, 8);
    chk(last_lead == 1, "R6 cas lead", last_lead, 1);
    setup(0, 1, 1, 2, 0, 0, 1);
    cyc(100);
    chk(last_ras == 1, "R7 minimum ras width", last_ras, 1);
    chk(last_pre == 1, "R8 minimum precharge", last_pre, 1);

    // R5 R9: bus held off, requests merge
    setup(0, 1, 1, 3, 0, 0, 0);
    cyc(1);
    chk(busy_o == 0, "R10 idle before merge test", busy_o, 0);
    cyc(120);
    chk(pending_o == 1 && cas_no, "R5 held while bus busy", pending_o, 1);
    cas_falls = 0;
    bus_avail_i = 1'b1;
    cyc(3);
    bus_avail_i = 1'b0;
    cyc(10);
    chk(cas_falls == 1, "R9 merged into one cycle", cas_falls, 1);

    // R2: every prescaler select
    for (int s = 2; s <= 7; s++) begin
      setup(0, 1, s, (s >= 6) ? 1 : 2, s % 8, (7 - s), 1);
      write_cnt(0);
      cyc((s >= 5) ? 9000 : 1200);
    end

    // R10: tight back-to-back requests with long cycle
    setup(0, 1, 1, 0, 7, 7, 1);
    write_cnt(0);
    cyc(200);
    chk(1, "R10 back-to-back compared per cycle", 0, 0);

    summary();
  end
endmodule